// File: doc/BRIEF.md
# Parallel 8080-style panel frame writer

This block pushes one frame of pixel words into a display panel that keeps its own graphics memory, over a parallel bus with an active-low chip select, an active-low write strobe and a data bus. Every word is sent as a separate bus cycle with four programmable phases. Chip select goes low first. Then comes a setup time before the strobe, a strobe-low time, and a hold time during which the data stays valid after the strobe rises. Chip select then returns high. The block never sends a frame on its own. A transfer starts only on a software trigger, or on a tearing-effect pulse from the panel when a frame update is waiting.

Pixel words come in on a valid/ready stream. `px_ready` is high only while the engine sits between bus cycles waiting for its next word. A word is taken on the rising edge where `px_valid` and `px_ready` are both high. The source may hold `px_valid` low for any number of cycles: the engine waits with chip select high, and the bus timing of the words it has already taken is not affected. The source must keep `px_data` steady while `px_valid` is high and `px_ready` is low. `busy` marks a frame in flight. `frame_done` pulses once when the frame has gone out, and any trigger that arrives while `busy` is high is dropped.

Top module: `i80_wr_engine`

## Requirements
- R1: After reset `lcd_cs_n` and `lcd_wr_n` are 1, and `busy`, `px_ready` and `frame_done` are 0.
- R2: `cfg_word` holds four 4-bit phase counts: the chip-select lead at bits 19:16, the strobe setup at 15:12, the strobe-low time at 11:8 and the data hold at 7:4. A count n lasts n+1 clocks. Each word's bus cycle therefore shows (lead+1)+(setup+1) clocks with chip select low and the strobe high, then strobe-low+1 clocks with the strobe low, then hold+1 clocks with the strobe high, and after that chip select rises.
- R3: The strobe is low only while chip select is low, and `lcd_data` does not change while chip select stays low. The data on the bus is the accepted pixel word.
- R4: `px_ready` is high only while `busy` is high and chip select is high. Exactly FRAME_LEN words are accepted and written per frame, in stream order, whatever gaps the source leaves.
- R5: With `cfg_word` bit 0 (interface enable) set and the engine idle, a cycle in which `trig_ctrl` bit 0 (trigger mode) and bit 1 (software trigger command) are both 1 makes `busy` high on the next clock.
- R6: A software or tearing-effect trigger that arrives while `busy` is high starts no extra frame and does not use up a pending update.
- R7: A rising edge on `te_in` starts a frame when `trig_ctrl` bit 3 (hardware trigger enable) is 1, bit 4 (hardware trigger mask) is 0, the engine is idle and at least one update is pending. Each `frame_upd` pulse adds one pending update (the count saturates), and each such start uses up one.
- R8: A `te_in` edge while no update is pending, or while bit 4 is 1, leaves `busy` low.
- R9: `frame_done` is a one-clock pulse in the clock after the last word's hold phase ends, and `busy` drops in that same clock.
- R10: No frame starts without a trigger, and with `cfg_word` bit 0 clear every trigger is ignored.
- R11: The phase counts are captured when a frame starts. Changing `cfg_word` during a frame changes the timing only from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Phase counts and interface enable (R2, R5) |
| trig_ctrl | input | 5 | Trigger control bits (R5, R7) |
| te_in | input | 1 | Tearing-effect input from the panel |
| frame_upd | input | 1 | One-clock pulse: a new frame update is pending |
| px_valid | input | 1 | Pixel stream valid |
| px_ready | output | 1 | Pixel stream ready |
| px_data | input | DATA_W | Pixel stream word |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DATA_W | Panel data bus |
| busy | output | 1 | Frame transfer in progress |
| frame_done | output | 1 | One-clock pulse when the frame is complete |

## Verification
A bad phase counter shows up within the same bus cycle as a wrong number of strobe-low or chip-select-low clocks. The scoreboard measures these clocks on every word. A bad word index or trigger state shows up at the end of the frame as a wrong number of accepted words, a missing or extra `frame_done`, or `busy` staying high. A pending count that is consumed or kept wrongly shows up on the next tearing-effect pulse, when a frame starts or fails to start against the bench's own count.

// File: rtl/i80_pkg.sv
package i80_pkg;
  localparam int PHASE_W       = 4;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_HOLD_LSB  = 4;
  localparam int CFG_ACT_LSB   = 8;
  localparam int CFG_WRS_LSB   = 12;
  localparam int CFG_CSS_LSB   = 16;
  localparam int TRG_MODE_BIT  = 0;
  localparam int TRG_SW_BIT    = 1;
  localparam int TRG_HWEN_BIT  = 3;
  localparam int TRG_MASK_BIT  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CSS, ST_WRS, ST_WRA, ST_WRH
  } phase_e;

  typedef struct packed {
    logic [PHASE_W-1:0] cs_set;
    logic [PHASE_W-1:0] wr_set;
    logic [PHASE_W-1:0] wr_act;
    logic [PHASE_W-1:0] wr_hold;
  } timing_t;

  function automatic timing_t unpack_timing(input logic [31:0] w);
    timing_t t;
    t.cs_set  = w[CFG_CSS_LSB  +: PHASE_W];
    t.wr_set  = w[CFG_WRS_LSB  +: PHASE_W];
    t.wr_act  = w[CFG_ACT_LSB  +: PHASE_W];
    t.wr_hold = w[CFG_HOLD_LSB +: PHASE_W];
    return t;
  endfunction

  function automatic logic sw_request(input logic [4:0] tc);
    return tc[TRG_MODE_BIT] & tc[TRG_SW_BIT];
  endfunction

  function automatic logic hw_armed(input logic [4:0] tc);
    return tc[TRG_HWEN_BIT] & ~tc[TRG_MASK_BIT];
  endfunction
endpackage

// File: rtl/i80_cfg_hold.sv
module i80_cfg_hold
  import i80_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] cfg_word,
  output timing_t     timing_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    timing_o <= '0;
    else if (load) timing_o <= unpack_timing(cfg_word);
  end
endmodule

// File: rtl/i80_trig_ctl.sv
module i80_trig_ctl
  import i80_pkg::*;
#(
  parameter int PEND_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       idle,
  input  logic [4:0] trig_ctrl,
  input  logic       te_in,
  input  logic       frame_upd,
  output logic       start
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic              te_q;
  logic [PEND_W-1:0] pend;
  logic              te_rise, hw_fire, sw_fire, consume, incr;

  assign te_rise = te_in & ~te_q;
  assign sw_fire = sw_request(trig_ctrl);
  assign hw_fire = hw_armed(trig_ctrl) & te_rise & (pend != '0);
  assign start   = idle & if_en & (sw_fire | hw_fire);
  assign consume = start & hw_fire;
  assign incr    = frame_upd & ((pend != PEND_MAX) | consume);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q <= 1'b0;
      pend <= '0;
    end else begin
      te_q <= te_in;
      unique case ({incr, consume})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end
endmodule

// File: rtl/i80_phase_seq.sv
module i80_phase_seq
  import i80_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  timing_t           timing,
  input  logic              px_valid,
  input  logic [DATA_W-1:0] px_data,
  output logic              px_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] data_o,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  phase_e             state;
  logic [PHASE_W-1:0] cnt;
  logic [IDX_W-1:0]   idx;
  logic [DATA_W-1:0]  data_q;
  logic               done_q;
  logic               cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_FETCH;
          idx   <= '0;
        end
        ST_FETCH: if (px_valid) begin
          data_q <= px_data;
          cnt    <= timing.cs_set;
          state  <= ST_CSS;
        end
        ST_CSS: if (cnt_zero) begin
          cnt   <= timing.wr_set;
          state <= ST_WRS;
        end else cnt <= cnt - 1'b1;
        ST_WRS: if (cnt_zero) begin
          cnt   <= timing.wr_act;
          state <= ST_WRA;
        end else cnt <= cnt - 1'b1;
        ST_WRA: if (cnt_zero) begin
          cnt   <= timing.wr_hold;
          state <= ST_WRH;
        end else cnt <= cnt - 1'b1;
        ST_WRH: if (cnt_zero) begin
          if (idx == LAST_IDX) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_FETCH;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign px_ready = (state == ST_FETCH);
  assign cs_n     = (state == ST_IDLE) || (state == ST_FETCH);
  assign wr_n     = (state != ST_WRA);
  assign data_o   = data_q;
  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/i80_wr_engine.sv
module i80_wr_engine
  import i80_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int FRAME_LEN = 8,
  parameter int PEND_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic [4:0]        trig_ctrl,
  input  logic              te_in,
  input  logic              frame_upd,
  input  logic              px_valid,
  output logic              px_ready,
  input  logic [DATA_W-1:0] px_data,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic [DATA_W-1:0] lcd_data,
  output logic              busy,
  output logic              frame_done
);
  logic    start;
  timing_t timing;

  i80_trig_ctl #(.PEND_W(PEND_W)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_en     (cfg_word[CFG_EN_BIT]),
    .idle      (~busy),
    .trig_ctrl (trig_ctrl),
    .te_in     (te_in),
    .frame_upd (frame_upd),
    .start     (start)
  );

  i80_cfg_hold u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .cfg_word (cfg_word),
    .timing_o (timing)
  );

  i80_phase_seq #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .timing   (timing),
    .px_valid (px_valid),
    .px_data  (px_data),
    .px_ready (px_ready),
    .cs_n     (lcd_cs_n),
    .wr_n     (lcd_wr_n),
    .data_o   (lcd_data),
    .busy     (busy),
    .done     (frame_done)
  );
endmodule

// File: rtl/i80_wr_engine_chk.sv
module i80_wr_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_word,
  input logic [4:0]        trig_ctrl,
  input logic              px_ready,
  input logic              lcd_cs_n,
  input logic              lcd_wr_n,
  input logic [DATA_W-1:0] lcd_data,
  input logic              busy,
  input logic              frame_done
);
  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);

  assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_data));

  assert_ready_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    px_ready |-> (busy && lcd_cs_n));

  assert_sw_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_word[0] && trig_ctrl[0] && trig_ctrl[1]) |=> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> frame_done);

  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_word[0]) |=> !busy);
endmodule

bind i80_wr_engine i80_wr_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_word   (cfg_word),
  .trig_ctrl  (trig_ctrl),
  .px_ready   (px_ready),
  .lcd_cs_n   (lcd_cs_n),
  .lcd_wr_n   (lcd_wr_n),
  .lcd_data   (lcd_data),
  .busy       (busy),
  .frame_done (frame_done)
);

// File: tb/sim_i80_wr_engine.sv
module sim_i80_wr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int FRAME_LEN  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       cfg_word = '0;
  logic [4:0]        trig_ctrl = '0;
  logic              te_in = 1'b0;
  logic              frame_upd = 1'b0;
  logic              px_valid = 1'b0;
  logic              px_ready;
  logic [DATA_W-1:0] px_data = '0;
  logic              lcd_cs_n, lcd_wr_n, busy, frame_done;
  logic [DATA_W-1:0] lcd_data;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int e_cs = 0, e_ws = 0, e_act = 0, e_hold = 0;
  logic [DATA_W-1:0] sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i80_wr_engine #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_ctrl(trig_ctrl),
    .te_in(te_in), .frame_upd(frame_upd), .px_valid(px_valid),
    .px_ready(px_ready), .px_data(px_data), .lcd_cs_n(lcd_cs_n),
    .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data), .busy(busy),
    .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] make_cfg(int cs, int ws, int act, int hold, int en);
    return (32'(cs) << 16) | (32'(ws) << 12) | (32'(act) << 8) |
           (32'(hold) << 4) | 32'(en);
  endfunction

  // Monitor: measures every bus cycle and pops the scoreboard.
  int pre_n = 0, lo_n = 0, post_n = 0, words = 0;
  bit seen_lo = 0;
  logic prev_cs = 1'b1;
  logic [DATA_W-1:0] cur_d = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_cs_n) begin
        cur_d = lcd_data;
        if (!lcd_wr_n) begin lo_n++; seen_lo = 1; end
        else if (seen_lo) post_n++;
        else pre_n++;
      end
      if (lcd_cs_n && !prev_cs) begin
        chk(pre_n == e_cs + e_ws + 2, "R2", "lead+setup clocks", pre_n, e_cs + e_ws + 2);
        chk(lo_n == e_act + 1, "R2", "strobe-low clocks", lo_n, e_act + 1);
        chk(post_n == e_hold + 1, "R2", "hold clocks", post_n, e_hold + 1);
        if (sb.size() == 0) chk(0, "R4", "unexpected word", int'(cur_d), -1);
        else begin
          logic [DATA_W-1:0] e;
          e = sb.pop_front();
          chk(cur_d == e, "R3", "bus data", int'(cur_d), int'(e));
        end
        words++;
        pre_n = 0; lo_n = 0; post_n = 0; seen_lo = 0;
      end
      if (frame_done) begin
        done_cnt++;
        chk(busy == 1'b0, "R9", "busy at frame_done", int'(busy), 0);
        chk(words == FRAME_LEN, "R4", "words per frame", words, FRAME_LEN);
        chk(sb.size() == 0, "R4", "scoreboard left", sb.size(), 0);
        words = 0;
      end
      prev_cs = lcd_cs_n;
    end
  end

  // Driver: feeds one frame, pushing expected words into the scoreboard.
  task automatic feed(input int base, input int gap);
    for (int i = 0; i < FRAME_LEN; i++) begin
      repeat (gap) @(negedge clk);
      px_data  = DATA_W'(base + i);
      px_valid = 1'b1;
      while (!px_ready) @(negedge clk);
      sb.push_back(px_data);
      @(negedge clk);
      px_valid = 1'b0;
    end
  endtask

  task automatic sw_pulse();
    @(negedge clk);
    trig_ctrl = trig_ctrl | 5'b00011;
    @(negedge clk);
    trig_ctrl = trig_ctrl & 5'b11101;
  endtask

  task automatic te_pulse();
    @(negedge clk); te_in = 1'b1;
    @(negedge clk); te_in = 1'b0;
  endtask

  task automatic upd_pulse();
    @(negedge clk); frame_upd = 1'b1;
    @(negedge clk); frame_upd = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic set_timing(input int cs, input int ws, input int act, input int hold);
    e_cs = cs; e_ws = ws; e_act = act; e_hold = hold;
    cfg_word = make_cfg(cs, ws, act, hold, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(lcd_cs_n && lcd_wr_n, "R1", "cs/wr idle", {lcd_cs_n, lcd_wr_n}, 3);
    chk(!busy && !px_ready && !frame_done, "R1", "busy/ready/done",
        {busy, px_ready, frame_done}, 0);

    // R10: interface disabled, software trigger ignored
    cfg_word = make_cfg(0, 0, 0, 0, 0);
    trig_ctrl = 5'b00001;
    sw_pulse();
    repeat (5) @(negedge clk);
    chk(!busy, "R10", "busy with interface off", busy, 0);
    chk(done_cnt == 0, "R10", "frames without trigger", done_cnt, 0);

    // R5, R2: minimum timing, back-to-back words
    set_timing(0, 0, 0, 0);
    sw_pulse();
    chk(busy, "R5", "busy after sw trigger", busy, 1);
    feed(16'h0100, 0);
    wait_done(1);
    chk(done_cnt == 1, "R9", "frames after first", done_cnt, 1);

    // R4, R6: wider phases, source gaps, triggers while busy
    set_timing(2, 1, 3, 2);
    trig_ctrl = 5'b01001;
    upd_pulse();
    sw_pulse();
    chk(busy, "R5", "busy after second trigger", busy, 1);
    fork
      feed(16'h0200, 3);
      begin
        repeat (12) @(negedge clk);
        sw_pulse();
        te_pulse();
      end
    join
    wait_done(2);
    repeat (30) @(negedge clk);
    chk(!busy, "R6", "busy after ignored triggers", busy, 0);
    chk(done_cnt == 2, "R6", "frames after ignored triggers", done_cnt, 2);
    // R6: the pending update survived the ignored edge
    te_pulse();
    chk(busy, "R6", "pending kept through busy edge", busy, 1);
    feed(16'h0280, 0);
    wait_done(3);

    // R11: timing captured at start
    set_timing(1, 0, 1, 0);
    sw_pulse();
    fork
      feed(16'h0300, 1);
      begin
        repeat (3) @(negedge clk);
        cfg_word = make_cfg(3, 3, 3, 3, 1);
      end
    join
    wait_done(4);
    set_timing(3, 3, 3, 3);
    sw_pulse();
    feed(16'h0400, 0);
    wait_done(5);
    chk(done_cnt == 5, "R11", "frames after timing change", done_cnt, 5);

    // R7, R8: tearing-effect triggering
    set_timing(0, 1, 0, 1);
    trig_ctrl = 5'b01000;
    te_pulse();
    chk(!busy, "R8", "edge with nothing pending", busy, 0);
    upd_pulse();
    upd_pulse();
    te_pulse();
    chk(busy, "R7", "edge with pending", busy, 1);
    feed(16'h0500, 0);
    wait_done(6);
    te_pulse();
    chk(busy, "R7", "second pending", busy, 1);
    feed(16'h0600, 2);
    wait_done(7);
    te_pulse();
    chk(!busy, "R7", "pending used up", busy, 0);
    upd_pulse();
    trig_ctrl = 5'b11000;
    te_pulse();
    chk(!busy, "R8", "masked edge", busy, 0);
    trig_ctrl = 5'b01000;
    te_pulse();
    chk(busy, "R7", "unmasked edge", busy, 1);
    feed(16'h0700, 0);
    wait_done(8);
    repeat (10) @(negedge clk);
    chk(done_cnt == 8, "R10", "total frames", done_cnt, 8);
    chk(lcd_cs_n && lcd_wr_n && !busy, "R1", "idle at end",
        {lcd_cs_n, lcd_wr_n, busy}, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule